// File: doc/BRIEF.md
# Two-Pass Stream Channel Arbiter

This block shares a small pool of data channels among a ring of nodes. It does so through a serial arbitration stream that is separate from the data channels. A stream starts empty at node 0, which is the origin. On the first pass it moves one node per clock. Each node writes its own slot as the stream goes by, and that slot depends only on the node's local inputs. The slot says whether the node wants to send, which node it wants to send to, and whether the node can receive right now. The node never reads the arriving stream, so nothing on the propagation path depends on its contents.

Once the last node has written its slot, the complete stream makes a second pass. It is relayed one node per clock and is never modified. Each node carries its own copy of the same decoder. From the finished stream, that decoder works out whether the node sends this round and on which channel, and whether it listens and on which channel. Because every node applies the same deterministic rule, all nodes reach the same assignment with no central arbiter.

The decisions of all nodes are lined up so that one round's grants appear together for a single data cycle: one flit per grant. A new round launches every clock, so arbitration overlaps with the data transfer.

Top module: `stream_chan_arbiter`

## Requirements
- R1: While `rst` is high, every output is zero after each clock edge. This covers `tx_grant`, `tx_chan`, `rx_listen` and `rx_chan`.
- R2: A round launched at edge E samples node k's `req_valid`, `req_dst` and `rx_ready` at edge E+k. The round's results are on the outputs after edge E+2·N_NODES.
- R3: Requests are taken in ascending node order. A request from node k wins only if all of the following hold:
  - `req_valid[k]` is set;
  - its destination d is not k;
  - node d reported `rx_ready` in this round;
  - no earlier request in this round has claimed d;
  - fewer than N_CHANS requests have already won.
- R4: The j-th winner in node order, counting from 0, gets channel j, written as a binary channel number on `tx_chan[k]`. A node that does not win shows `tx_chan[k]` = 0.
- R5: The destination of each winner raises `rx_listen` and shows the winner's channel number on `rx_chan`. A node that no winner targets shows `rx_listen` = 0 and `rx_chan` = 0.
- R6: A request whose destination equals the requesting node is ignored. It wins nothing, claims no destination and uses no channel.
- R7: In one round, a node can be both a winning sender and a listening destination, and the two use different channels.
- R8: A new round starts on every clock. A grant lasts exactly one cycle, for one flit, and the next cycle's outputs come only from the next round.
- R9: In every round:
  - no two senders share a channel;
  - at most N_CHANS grants are made;
  - each grant goes to a destination that was ready;
  - the number of listeners equals the number of senders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_NODES | Per node: wants to send a flit this round |
| req_dst | input | N_NODES×clog2(N_NODES) | Per node: binary destination node number |
| rx_ready | input | N_NODES | Per node: can accept a flit this round |
| tx_grant | output | N_NODES | Per node: transmits on `tx_chan` this cycle |
| tx_chan | output | N_NODES×clog2(N_CHANS) | Per node: channel to transmit on |
| rx_listen | output | N_NODES | Per node: receives on `rx_chan` this cycle |
| rx_chan | output | N_NODES×clog2(N_CHANS) | Per node: channel to listen on |

## Verification
Node k's inputs belong to the round launched k edges earlier, and that round's grants and listen settings are due 2·N_NODES edges after launch (16 with the default eight nodes). The driver records every cycle's inputs. It builds a round's expected result as soon as the last node's slot has been sampled, and stamps it with the edge at which the result falls due. The monitor samples the outputs 1 ns after each rising edge and compares an item only on its due edge. An early or late result is therefore reported rather than absorbed. Each round is also checked against the per-round invariants of R9.

// File: rtl/stream_arb_pkg.sv
package stream_arb_pkg;

  // Bits needed to encode values 0..count-1 (at least one bit).
  function automatic int width_of(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/stream_append_stage.sv
// One hop of the first pass: the node overwrites its own slot with its local
// field. The arriving stream is passed through untouched and never decoded.
module stream_append_stage #(
  parameter int STREAM_W = 40,
  parameter int FIELD_W  = 5,
  parameter int SLOT     = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [STREAM_W-1:0] stream_in,
  input  logic [FIELD_W-1:0]  field_in,
  output logic [STREAM_W-1:0] stream_q
);

  logic [STREAM_W-1:0] merged;

  always_comb begin
    merged = stream_in;
    merged[SLOT*FIELD_W +: FIELD_W] = field_in;
  end

  always_ff @(posedge clk) begin
    if (rst) stream_q <= '0;
    else     stream_q <= merged;
  end

endmodule

// File: rtl/stream_delay_line.sv
// Fixed-depth register delay; depth 0 is a plain wire.
module stream_delay_line #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign dout = din;
    end else begin : g_regs
      logic [WIDTH-1:0] stage_q [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
        end else begin
          stage_q[0] <= din;
          for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign dout = stage_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/stream_slot_decoder.sv
// Second-pass decoder owned by one node. It evaluates the shared grant rule
// over the whole finished stream and keeps only this node's outcome, then
// delays it so that every node's outcome leaves on the same edge.
module stream_slot_decoder
  import stream_arb_pkg::*;
#(
  parameter int N_NODES = 8,
  parameter int N_CHANS = 4,
  parameter int NODE    = 0,
  localparam int DW = width_of(N_NODES),
  localparam int CW = width_of(N_CHANS),
  localparam int FW = DW + 2,
  localparam int SW = N_NODES * FW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] stream_in,
  output logic          tx_grant,
  output logic [CW-1:0] tx_chan,
  output logic          rx_listen,
  output logic [CW-1:0] rx_chan
);

  localparam int NSLOT = 1 << DW;
  localparam int UW    = width_of(N_CHANS + 1);
  localparam int BW    = 2 + 2 * CW;
  localparam int ALIGN = N_NODES - NODE;

  logic [NSLOT-1:0] ready_map;
  logic [NSLOT-1:0] claimed;
  logic [UW-1:0]    used;
  logic [DW-1:0]    dst;
  logic             want;
  logic             my_grant, my_listen;
  logic [CW-1:0]    my_tx, my_rx;

  always_comb begin
    ready_map = '0;
    for (int i = 0; i < N_NODES; i++) ready_map[i] = stream_in[i*FW];
    claimed   = '0;
    used      = '0;
    dst       = '0;
    want      = 1'b0;
    my_grant  = 1'b0;
    my_listen = 1'b0;
    my_tx     = '0;
    my_rx     = '0;
    for (int i = 0; i < N_NODES; i++) begin
      want = stream_in[i*FW + FW - 1];
      dst  = stream_in[i*FW + 1 +: DW];
      if (want && (dst != DW'(i)) && ready_map[dst] && !claimed[dst] &&
          (used < UW'(N_CHANS))) begin
        claimed[dst] = 1'b1;
        if (i == NODE) begin
          my_grant = 1'b1;
          my_tx    = CW'(used);
        end
        if (dst == DW'(NODE)) begin
          my_listen = 1'b1;
          my_rx     = CW'(used);
        end
        used = used + UW'(1);
      end
    end
  end

  logic [BW-1:0] outcome, aligned;
  assign outcome = {my_grant, my_tx, my_listen, my_rx};

  stream_delay_line #(.WIDTH(BW), .DEPTH(ALIGN)) u_align (
    .clk  (clk),
    .rst  (rst),
    .din  (outcome),
    .dout (aligned)
  );

  assign {tx_grant, tx_chan, rx_listen, rx_chan} = aligned;

endmodule

// File: rtl/stream_chan_arbiter.sv
module stream_chan_arbiter #(
  parameter int N_NODES = 8,
  parameter int N_CHANS = 4,
  localparam int DW = stream_arb_pkg::width_of(N_NODES),
  localparam int CW = stream_arb_pkg::width_of(N_CHANS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_NODES-1:0]         req_valid,
  input  logic [N_NODES-1:0][DW-1:0] req_dst,
  input  logic [N_NODES-1:0]         rx_ready,
  output logic [N_NODES-1:0]         tx_grant,
  output logic [N_NODES-1:0][CW-1:0] tx_chan,
  output logic [N_NODES-1:0]         rx_listen,
  output logic [N_NODES-1:0][CW-1:0] rx_chan
);

  // Slot layout per node: {want, destination, ready}.
  localparam int FW = DW + 2;
  localparam int SW = N_NODES * FW;

  logic [SW-1:0] empty_stream;
  logic [SW-1:0] trip1 [N_NODES];
  logic [SW-1:0] relay [N_NODES];

  assign empty_stream = '0;

  // First pass: one hop per clock, starting empty at node 0.
  generate
    for (genvar k = 0; k < N_NODES; k++) begin : g_pass1
      logic [FW-1:0] field;
      assign field = {req_valid[k], req_dst[k], rx_ready[k]};
      if (k == 0) begin : g_origin
        stream_append_stage #(.STREAM_W(SW), .FIELD_W(FW), .SLOT(k)) u_hop (
          .clk(clk), .rst(rst), .stream_in(empty_stream),
          .field_in(field), .stream_q(trip1[k])
        );
      end else begin : g_follow
        stream_append_stage #(.STREAM_W(SW), .FIELD_W(FW), .SLOT(k)) u_hop (
          .clk(clk), .rst(rst), .stream_in(trip1[k-1]),
          .field_in(field), .stream_q(trip1[k])
        );
      end
    end
  endgenerate

  // Second pass: the finished stream is relayed unchanged, one hop per clock.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_NODES; i++) relay[i] <= '0;
    end else begin
      relay[0] <= trip1[N_NODES-1];
      for (int i = 1; i < N_NODES; i++) relay[i] <= relay[i-1];
    end
  end

  generate
    for (genvar k = 0; k < N_NODES; k++) begin : g_pass2
      stream_slot_decoder #(.N_NODES(N_NODES), .N_CHANS(N_CHANS), .NODE(k)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .stream_in (relay[k]),
        .tx_grant  (tx_grant[k]),
        .tx_chan   (tx_chan[k]),
        .rx_listen (rx_listen[k]),
        .rx_chan   (rx_chan[k])
      );
    end
  endgenerate

endmodule

// File: rtl/stream_chan_arbiter_chk.sv
module stream_chan_arbiter_chk #(
  parameter int N_NODES = 8,
  parameter int N_CHANS = 4,
  localparam int CW = stream_arb_pkg::width_of(N_CHANS)
) (
  input logic                       clk,
  input logic                       rst,
  input logic [N_NODES-1:0]         tx_grant,
  input logic [N_NODES-1:0][CW-1:0] tx_chan,
  input logic [N_NODES-1:0]         rx_listen,
  input logic [N_NODES-1:0][CW-1:0] rx_chan
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (tx_grant == '0 && rx_listen == '0 && tx_chan == '0 && rx_chan == '0));

  // R9
  grant_bound_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(tx_grant) <= N_CHANS);

  // R5
  listen_pairing_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(rx_listen) == $countones(tx_grant));

  generate
    for (genvar i = 0; i < N_NODES; i++) begin : g_node
      // R4
      idle_chan_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_grant[i] |-> tx_chan[i] == '0);
      for (genvar j = i + 1; j < N_NODES; j++) begin : g_pair
        // R4
        ascending_chan_chk: assert property (@(posedge clk) disable iff (rst)
          (tx_grant[i] && tx_grant[j]) |-> (tx_chan[i] < tx_chan[j]));
        // R9
        distinct_listen_chk: assert property (@(posedge clk) disable iff (rst)
          (rx_listen[i] && rx_listen[j]) |-> (rx_chan[i] != rx_chan[j]));
      end
    end
  endgenerate

endmodule

bind stream_chan_arbiter stream_chan_arbiter_chk #(
  .N_NODES(N_NODES), .N_CHANS(N_CHANS)
) i_chk (.*);

// File: tb/test_stream_chan_arbiter.sv
`timescale 1ns/1ps
module test_stream_chan_arbiter;
  localparam int N    = 8;
  localparam int C    = 4;
  localparam int DW   = stream_arb_pkg::width_of(N);
  localparam int CW   = stream_arb_pkg::width_of(C);
  localparam int HMAX = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [N-1:0]         req_valid;
  logic [N-1:0][DW-1:0] req_dst;
  logic [N-1:0]         rx_ready;
  logic [N-1:0]         tx_grant;
  logic [N-1:0][CW-1:0] tx_chan;
  logic [N-1:0]         rx_listen;
  logic [N-1:0][CW-1:0] rx_chan;

  stream_chan_arbiter #(.N_NODES(N), .N_CHANS(C)) i_stream_chan_arbiter (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_dst(req_dst),
    .rx_ready(rx_ready), .tx_grant(tx_grant), .tx_chan(tx_chan),
    .rx_listen(rx_listen), .rx_chan(rx_chan)
  );

  typedef struct {
    int                   due;
    string                tag;
    logic [N-1:0]         g;
    logic [N-1:0][CW-1:0] tc;
    logic [N-1:0]         l;
    logic [N-1:0][CW-1:0] rc;
    logic [N-1:0]         rdy;
    logic [N-1:0][DW-1:0] dst;
  } exp_t;

  exp_t exp_q[$];
  logic [N-1:0]         h_req [HMAX];
  logic [N-1:0][DW-1:0] h_dst [HMAX];
  logic [N-1:0]         h_rdy [HMAX];
  string                h_tag [HMAX];

  int  checks = 0;
  int  errors = 0;
  int  pidx   = 0;
  int  ecount = 0;
  bit  running = 1'b0;
  bit  done    = 1'b0;

  task automatic check(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, expv);
    end
  endtask

  // Expected outcome of the round launched at edge e (R2, R3, R4, R5, R6).
  function automatic exp_t build(input int e);
    exp_t x;
    logic [N-1:0] taken;
    int nxt;
    x.due = e + 2 * N;
    x.tag = h_tag[e + N - 1];
    x.g = '0; x.tc = '0; x.l = '0; x.rc = '0;
    for (int k = 0; k < N; k++) begin
      x.rdy[k] = h_rdy[e + k][k];
      x.dst[k] = h_dst[e + k][k];
    end
    taken = '0;
    nxt = 0;
    for (int k = 0; k < N; k++) begin
      int d;
      d = int'(x.dst[k]);
      if (h_req[e + k][k] && d != k && x.rdy[d] && !taken[d] && nxt < C) begin
        x.g[k]  = 1'b1;
        x.tc[k] = CW'(nxt);
        x.l[d]  = 1'b1;
        x.rc[d] = CW'(nxt);
        taken[d] = 1'b1;
        nxt++;
      end
    end
    return x;
  endfunction

  // Driver: called at a falling edge; sets the inputs for edge pidx.
  task automatic drive(input string tag, input logic [N-1:0] rq,
                       input logic [N-1:0][DW-1:0] ds, input logic [N-1:0] rd);
    req_valid = rq;
    req_dst   = ds;
    rx_ready  = rd;
    h_req[pidx] = rq;
    h_dst[pidx] = ds;
    h_rdy[pidx] = rd;
    h_tag[pidx] = tag;
    if (pidx >= N - 1) exp_q.push_back(build(pidx - N + 1));
    pidx++;
    @(negedge clk);
  endtask

  task automatic hold(input string tag, input logic [N-1:0] rq,
                      input logic [N-1:0][DW-1:0] ds, input logic [N-1:0] rd,
                      input int cycles);
    for (int i = 0; i < cycles; i++) drive(tag, rq, ds, rd);
  endtask

  // Monitor: compare each expected round on its due edge.
  initial begin
    exp_t x;
    wait (running);
    forever begin
      @(posedge clk);
      #1;
      while (exp_q.size() > 0 && exp_q[0].due <= ecount) begin
        bit ok;
        int cnt;
        x = exp_q.pop_front();
        check(x.due == ecount, $sformatf("%s/R2 result missed its edge", x.tag),
              64'(ecount), 64'(x.due));
        check(tx_grant == x.g, $sformatf("%s/R3 tx_grant edge %0d", x.tag, ecount),
              64'(tx_grant), 64'(x.g));
        check(tx_chan == x.tc, $sformatf("%s/R4 tx_chan edge %0d", x.tag, ecount),
              64'(tx_chan), 64'(x.tc));
        check(rx_listen == x.l, $sformatf("%s/R5 rx_listen edge %0d", x.tag, ecount),
              64'(rx_listen), 64'(x.l));
        check(rx_chan == x.rc, $sformatf("%s/R5 rx_chan edge %0d", x.tag, ecount),
              64'(rx_chan), 64'(x.rc));
        ok = 1'b1;
        cnt = 0;
        for (int k = 0; k < N; k++) begin
          if (tx_grant[k]) begin
            int d;
            d = int'(x.dst[k]);
            cnt++;
            if (!x.rdy[d]) ok = 1'b0;
            if (!rx_listen[d] || rx_chan[d] != tx_chan[k]) ok = 1'b0;
            for (int j = k + 1; j < N; j++)
              if (tx_grant[j] && tx_chan[j] == tx_chan[k]) ok = 1'b0;
          end
        end
        if (cnt > C || cnt != $countones(rx_listen)) ok = 1'b0;
        check(ok, $sformatf("%s/R9 round invariants edge %0d", x.tag, ecount),
              64'(cnt), 64'($countones(x.g)));
      end
      ecount++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog expired actual=%0d expected=0 pending", exp_q.size());
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0][DW-1:0] d;
    logic [N-1:0]         r;
    logic [N-1:0]         q;
    req_valid = '0;
    req_dst   = '0;
    rx_ready  = '0;
    // R1: traffic during reset must not reach the outputs.
    @(negedge clk);
    req_valid = '1;
    rx_ready  = '1;
    for (int k = 0; k < N; k++) req_dst[k] = DW'((k + 1) % N);
    repeat (2 * N + 2) @(posedge clk);
    #1;
    check(tx_grant == '0 && rx_listen == '0 && tx_chan == '0 && rx_chan == '0,
          "R1 outputs during reset", {tx_grant, rx_listen, tx_chan, rx_chan}, 64'd0);
    @(negedge clk);
    rst = 1'b0;
    running = 1'b1;

    hold("R8 idle", '0, '0, '1, 2 * N);

    // R2: a single 0->3 request appears exactly 2N edges after launch.
    d = '0; d[0] = DW'(3);
    hold("R2 latency", 8'b0000_0001, d, '1, 2 * N);
    hold("R8 idle", '0, '0, '1, 2 * N);

    // R3: 1->2 wins, 3->4 loses (4 not ready), 5->2 loses (claimed), 7->0 wins.
    d = '0; d[1] = DW'(2); d[3] = DW'(4); d[5] = DW'(2); d[7] = DW'(0);
    hold("R3 rule", 8'b1010_1010, d, 8'b1110_1111, 2 * N);

    // R4: six requesters to distinct ready nodes; first four win ch0..ch3.
    d = '0;
    for (int k = 0; k < 6; k++) d[k] = DW'(k + 1);
    hold("R4 order", 8'b0011_1111, d, '1, 2 * N);

    // R6: self-addressed requests use no channel.
    d = '0; d[0] = DW'(0); d[1] = DW'(1); d[2] = DW'(5); d[3] = DW'(6);
    d[4] = DW'(7); d[5] = DW'(0); d[6] = DW'(1);
    hold("R6 self", 8'b0111_1111, d, '1, 2 * N);

    // R7: nodes 0 and 1 send to each other in the same round.
    d = '0; d[0] = DW'(1); d[1] = DW'(0);
    hold("R7 dual", 8'b0000_0011, d, 8'b0000_0011, 2 * N);

    // R8: a fresh pattern on every clock.
    for (int i = 0; i < 400; i++) begin
      for (int k = 0; k < N; k++) begin
        q[k] = ($urandom % 10) < 6;
        r[k] = ($urandom % 10) < 7;
        d[k] = DW'($urandom % N);
      end
      drive("R8 random", q, d, r);
    end

    hold("R8 drain", '0, '0, '1, 3 * N);
    req_valid = '0;
    while (exp_q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule